// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

This block is a register-programmed watchdog. Software writes a timeout and sets an enable bit. From then on the counter steps down once on every half-second tick strobe. Before the count runs out, software must reload it with an ordered two-word key sequence. If it does not, the block raises a one-cycle system reset request and, when configured, a one-cycle pulse on the external watchdog output. The counter then reloads by itself and keeps running.

A separately programmed pre-timeout interrupt can warn software a chosen number of half-second steps before expiry. Software can also request a system reset or a watchdog output pulse directly, by writing zero to either of two self-restoring control bits. A read-only status register records whether the last reset came from power-on, from software or from a timeout. Three suspend inputs (stop, debug, wait) can each freeze counting when the matching control bit allows it.

Top module: `wdog_timer`

## Requirements
- R1: The timeout field sits in control register (offset 0x0) bits 15:8. A timeout fires on the (field+1)-th counted tick after the counter was loaded. Field 0 gives 1 tick and field 255 gives 256 ticks.
- R2: Control bit 2 enables the watchdog and resets to 0. While it is 0 no tick is counted and no timeout occurs. When it changes from 0 to 1, the counter loads the full programmed timeout in the following cycle.
- R3: Writing 0x5555 and then 0xAAAA to the service register (offset 0x2) reloads the counter to the full timeout. The service register reads as 0.
- R4: The interrupt control register (offset 0x6) holds the lead count in bits 7:0 (reset value 4), the interrupt enable in bit 15 and the status flag in bit 14. The flag is set on the counted tick that leaves exactly lead-count ticks remaining, and only while the enable is 1. The `irq` output equals the flag.
- R5: Control bits 0, 1 and 7 suspend counting while `in_stop`, `in_debug` and `in_wait` respectively are high. A suspend input has no effect while its control bit is 0.
- R6: A timeout produces a one-cycle `sys_rst_req` pulse. It also produces a one-cycle `wdog_out` pulse when control bit 3 is 1. The counter reloads and keeps counting.
- R7: Writing 0 to control bit 4 produces a one-cycle `sys_rst_req` pulse. Writing 0 to control bit 5 produces a one-cycle `wdog_out` pulse. Both bits always read 1.
- R8: The status register (offset 0x4) reads 0x0010 after power-on, 0x0001 after a software reset request and 0x0002 after a timeout. Writes to it are ignored.
- R9: After 0x5555, any service write other than 0xAAAA discards the sequence. A lone 0xAAAA does not reload the counter.
- R10: Writing 1 to interrupt bit 14 clears the flag. Writing 0 to it leaves the flag unchanged.
- R11: Reads return data one cycle after the read strobe. Reset values are: control 0x0030, interrupt control 0x0004, status 0x0010, and all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after reg_rd |
| tick_half_s | input | 1 | One-cycle half-second strobe |
| in_stop | input | 1 | Stop-mode indication |
| in_debug | input | 1 | Debug-halt indication |
| in_wait | input | 1 | Wait-mode indication |
| irq | output | 1 | Pre-timeout interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |
| wdog_out | output | 1 | One-cycle external watchdog output pulse |

## Verification
The bench counts ticks up to the exact expiry cycle, including the 256-tick extreme. A counter that is off by one, or that loaded a stale timeout when enabled, would pulse one tick early or late. The bench breaks the key sequence with a stray word and also sends 0xAAAA alone; a sequencer that remembers a partial sequence would reload and hide the timeout. The interrupt is checked at the exact remaining-tick count, with the enable off, and against write-zero to the flag; a wrong comparison or a plain-write flag would fire on the wrong tick or lose its status. Each suspend input is driven with its control bit both set and clear, so a gate that ignores its control bit would freeze, or fail to freeze, the expiry pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_SVC  = 2;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_ICR  = 6;

  localparam logic [15:0] KEY_ARM  = 16'h5555;
  localparam logic [15:0] KEY_FIRE = 16'hAAAA;

  typedef enum logic {
    SVC_IDLE  = 1'b0,
    SVC_ARMED = 1'b1
  } svc_state_e;

  typedef struct packed {
    logic wait_sus;
    logic sre;
    logic wdo_on_tout;
    logic en;
    logic dbg_sus;
    logic stop_sus;
  } ctrl_bits_t;
endpackage

// File: rtl/wdog_svc.sv
module wdog_svc
  import wdog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              reload_o
);
  svc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    reload_o = 1'b0;
    if (svc_wr_i) begin
      if (state_q == SVC_ARMED && wdata_i == DATA_W'(KEY_FIRE)) begin
        reload_o = 1'b1;
        state_d  = SVC_IDLE;
      end else if (wdata_i == DATA_W'(KEY_ARM)) begin
        state_d = SVC_ARMED;
      end else begin
        state_d = SVC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SVC_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [TMO_W-1:0] wt_i,
  input  logic [TMO_W-1:0] wict_i,
  output logic             tout_evt_o,
  output logic             pre_evt_o
);
  localparam int CNT_W = TMO_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val, rem_after;
  logic             en_prev_q;
  logic             step;

  assign load_val  = {1'b0, wt_i} + CNT_W'(1);
  assign rem_after = cnt_q - CNT_W'(1);
  assign step      = en_i && en_prev_q && tick_i && !hold_i && !reload_i;

  always_comb begin
    cnt_d      = cnt_q;
    tout_evt_o = 1'b0;
    pre_evt_o  = 1'b0;
    if (!en_i || !en_prev_q || reload_i) begin
      cnt_d = load_val;
    end else if (step) begin
      pre_evt_o = (rem_after == {1'b0, wict_i});
      if (cnt_q == CNT_W'(1)) begin
        cnt_d      = load_val;
        tout_evt_o = 1'b1;
      end else begin
        cnt_d = rem_after;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_W'(1);
      en_prev_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      en_prev_q <= en_i;
    end
  end

  assert_cnt_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tout_evt_i,
  input  logic              pre_evt_i,
  output logic [TMO_W-1:0]  wt_o,
  output logic [TMO_W-1:0]  wict_o,
  output ctrl_bits_t        ctrl_o,
  output logic              svc_wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              wdog_o
);
  localparam int PAD_ICR  = DATA_W - 2 - TMO_W;
  localparam int PAD_STAT = DATA_W - 5;

  logic [TMO_W-1:0]  wt_q, wt_d, wict_q, wict_d;
  ctrl_bits_t        bits_q, bits_d;
  logic              wie_q, wie_d, wtis_q, wtis_d;
  logic [2:0]        stat_q, stat_d;          // {por, tout, sft}
  logic              sw_rst_q, sw_rst_d, sw_wdo_q, sw_wdo_d, tout_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ctrl_wr, icr_wr;

  assign ctrl_wr  = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign icr_wr   = wr_en_i && (addr_i == ADDR_W'(OFS_ICR));
  assign svc_wr_o = wr_en_i && (addr_i == ADDR_W'(OFS_SVC));

  always_comb begin
    wt_d   = wt_q;
    bits_d = bits_q;
    if (ctrl_wr) begin
      wt_d               = wdata_i[DATA_W-1 -: TMO_W];
      bits_d.wait_sus    = wdata_i[7];
      bits_d.sre         = wdata_i[6];
      bits_d.wdo_on_tout = wdata_i[3];
      bits_d.en          = wdata_i[2];
      bits_d.dbg_sus     = wdata_i[1];
      bits_d.stop_sus    = wdata_i[0];
    end
    sw_rst_d = ctrl_wr && !wdata_i[4];
    sw_wdo_d = ctrl_wr && !wdata_i[5];
  end

  always_comb begin
    wict_d = wict_q;
    wie_d  = wie_q;
    wtis_d = wtis_q;
    if (icr_wr) begin
      wict_d = wdata_i[TMO_W-1:0];
      wie_d  = wdata_i[15];
      if (wdata_i[14]) wtis_d = 1'b0;
    end
    if (pre_evt_i && wie_q) wtis_d = 1'b1;
  end

  always_comb begin
    stat_d = stat_q;
    if (tout_evt_i)    stat_d = 3'b010;
    else if (sw_rst_d) stat_d = 3'b001;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en_i) begin
      rdata_d = '0;
      if (addr_i == ADDR_W'(OFS_CTRL))
        rdata_d = {wt_q, bits_q.wait_sus, bits_q.sre, 1'b1, 1'b1,
                   bits_q.wdo_on_tout, bits_q.en, bits_q.dbg_sus, bits_q.stop_sus};
      else if (addr_i == ADDR_W'(OFS_ICR))
        rdata_d = {wie_q, wtis_q, {PAD_ICR{1'b0}}, wict_q};
      else if (addr_i == ADDR_W'(OFS_STAT))
        rdata_d = {{PAD_STAT{1'b0}}, stat_q[2], 2'b00, stat_q[1], stat_q[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_q     <= '0;
      bits_q   <= '0;
      wict_q   <= TMO_W'(4);
      wie_q    <= 1'b0;
      wtis_q   <= 1'b0;
      stat_q   <= 3'b100;
      sw_rst_q <= 1'b0;
      sw_wdo_q <= 1'b0;
      tout_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      wt_q     <= wt_d;
      bits_q   <= bits_d;
      wict_q   <= wict_d;
      wie_q    <= wie_d;
      wtis_q   <= wtis_d;
      stat_q   <= stat_d;
      sw_rst_q <= sw_rst_d;
      sw_wdo_q <= sw_wdo_d;
      tout_q   <= tout_evt_i;
      rdata_q  <= rdata_d;
    end
  end

  assign wt_o      = wt_q;
  assign wict_o    = wict_q;
  assign ctrl_o    = bits_q;
  assign rdata_o   = rdata_q;
  assign irq_o     = wtis_q;
  assign rst_req_o = sw_rst_q | tout_q;
  assign wdog_o    = sw_wdo_q | (tout_q & bits_q.wdo_on_tout);

  assert_no_tout_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bits_q.en |=> !tout_q);
  assert_flag_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wtis_q) |-> $past(wie_q));
  assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat_q) == 1);
  assert_tout_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tout_q |-> stat_q == 3'b010);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              tick_half_s,
  input  logic              in_stop,
  input  logic              in_debug,
  input  logic              in_wait,
  output logic              irq,
  output logic              sys_rst_req,
  output logic              wdog_out
);
  localparam int DATA_W = 16;

  logic [TMO_W-1:0] wt, wict;
  ctrl_bits_t       ctrl;
  logic             svc_wr, reload, tout_evt, pre_evt, hold;

  assign hold = (ctrl.stop_sus & in_stop) | (ctrl.dbg_sus & in_debug) |
                (ctrl.wait_sus & in_wait);

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (reg_wr),
    .rd_en_i    (reg_rd),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .tout_evt_i (tout_evt),
    .pre_evt_i  (pre_evt),
    .wt_o       (wt),
    .wict_o     (wict),
    .ctrl_o     (ctrl),
    .svc_wr_o   (svc_wr),
    .rdata_o    (reg_rdata),
    .irq_o      (irq),
    .rst_req_o  (sys_rst_req),
    .wdog_o     (wdog_out)
  );

  wdog_svc #(.DATA_W(DATA_W)) svc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_wr_i (svc_wr),
    .wdata_i  (reg_wdata),
    .reload_o (reload)
  );

  wdog_counter #(.TMO_W(TMO_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (ctrl.en),
    .hold_i     (hold),
    .tick_i     (tick_half_s),
    .reload_i   (reload),
    .wt_i       (wt),
    .wict_i     (wict),
    .tout_evt_o (tout_evt),
    .pre_evt_o  (pre_evt)
  );
endmodule

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, tick_half_s, in_stop, in_debug, in_wait;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq, sys_rst_req, wdog_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic w_rst, w_wdo, s_rst, s_wdo, s_irq;
  logic [15:0] rv;

  always #2 clk = ~clk;

  wdog_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_half_s(tick_half_s), .in_stop(in_stop), .in_debug(in_debug),
    .in_wait(in_wait), .irq(irq), .sys_rst_req(sys_rst_req), .wdog_out(wdog_out)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; w_rst = sys_rst_req; w_wdo = wdog_out;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic tk();
    @(negedge clk); tick_half_s = 1'b1;
    @(negedge clk); tick_half_s = 1'b0;
    s_rst = sys_rst_req; s_wdo = wdog_out; s_irq = irq;
  endtask

  task automatic service();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
  endtask

  task automatic test_reset();
    chk("R11 rst_req", {15'd0, sys_rst_req}, 16'd0);
    chk("R11 wdog_out", {15'd0, wdog_out}, 16'd0);
    chk("R11 irq", {15'd0, irq}, 16'd0);
    rd(4'h0, rv); chk("R11 ctrl reset", rv, 16'h0030);
    rd(4'h6, rv); chk("R11 icr reset", rv, 16'h0004);
    rd(4'h4, rv); chk("R8 stat por", rv, 16'h0010);
    rd(4'h2, rv); chk("R3 svc reads 0", rv, 16'h0000);
  endtask

  task automatic test_disabled();
    for (int i = 0; i < 4; i++) begin tk(); chk("R2 disabled no tout", {15'd0, s_rst}, 16'd0); end
  endtask

  task automatic test_timeout();
    wr(4'h0, 16'h023C);
    for (int r = 0; r < 2; r++) begin
      tk(); chk("R1 tick1", {15'd0, s_rst}, 16'd0);
      tk(); chk("R1 tick2", {15'd0, s_rst}, 16'd0);
      tk(); chk("R6 rst_req on tout", {15'd0, s_rst}, 16'd1);
      chk("R6 wdog_out on tout", {15'd0, s_wdo}, 16'd1);
    end
    rd(4'h4, rv); chk("R8 stat tout", rv, 16'h0002);
    wr(4'h0, 16'h0234);
    tk(); tk(); chk("R6 no early", {15'd0, s_rst}, 16'd0);
    tk(); chk("R6 rst_req", {15'd0, s_rst}, 16'd1);
    chk("R6 wdog_out gated by bit3", {15'd0, s_wdo}, 16'd0);
  endtask

  task automatic test_service();
    wr(4'h0, 16'h0334); service();
    tk(); tk(); tk();
    chk("R3 before service", {15'd0, s_rst}, 16'd0);
    service();
    for (int i = 0; i < 3; i++) begin tk(); chk("R3 reloaded", {15'd0, s_rst}, 16'd0); end
    tk(); chk("R3 tout after full", {15'd0, s_rst}, 16'd1);
  endtask

  task automatic test_badkey();
    tk(); tk();
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    tk(); chk("R9 broken seq", {15'd0, s_rst}, 16'd0);
    tk(); chk("R9 broken seq no reload", {15'd0, s_rst}, 16'd1);
    tk(); tk();
    wr(4'h2, 16'hAAAA);
    tk(); chk("R9 lone key", {15'd0, s_rst}, 16'd0);
    tk(); chk("R9 lone key no reload", {15'd0, s_rst}, 16'd1);
  endtask

  task automatic test_irq();
    wr(4'h0, 16'h0434); service();
    wr(4'h6, 16'h8002);
    tk(); chk("R4 irq rem4", {15'd0, s_irq}, 16'd0);
    tk(); chk("R4 irq rem3", {15'd0, s_irq}, 16'd0);
    tk(); chk("R4 irq rem2", {15'd0, s_irq}, 16'd1);
    rd(4'h6, rv); chk("R4 icr flag", rv, 16'hC002);
    wr(4'h6, 16'h8002);
    rd(4'h6, rv); chk("R10 write0 keeps flag", rv, 16'hC002);
    wr(4'h6, 16'hC002);
    rd(4'h6, rv); chk("R10 write1 clears", rv, 16'h8002);
    chk("R10 irq low", {15'd0, irq}, 16'd0);
    tk(); chk("R4 no refire", {15'd0, s_irq}, 16'd0);
    tk(); chk("R4 tout", {15'd0, s_rst}, 16'd1);
    chk("R4 no irq at tout", {15'd0, s_irq}, 16'd0);
    wr(4'h6, 16'h0002);
    tk(); tk(); tk(); chk("R4 disabled irq", {15'd0, s_irq}, 16'd0);
    rd(4'h6, rv); chk("R4 no flag when off", rv, 16'h0002);
    tk(); tk();
  endtask

  task automatic test_suspend();
    wr(4'h0, 16'h0035); service();
    in_stop = 1'b1;
    tk(); chk("R5 stop hold", {15'd0, s_rst}, 16'd0);
    in_stop = 1'b0;
    tk(); chk("R5 stop release", {15'd0, s_rst}, 16'd1);
    wr(4'h0, 16'h0036); in_debug = 1'b1;
    tk(); chk("R5 debug hold", {15'd0, s_rst}, 16'd0);
    wr(4'h0, 16'h0034);
    tk(); chk("R5 debug ignored when bit clear", {15'd0, s_rst}, 16'd1);
    in_debug = 1'b0;
    wr(4'h0, 16'h00B4); in_wait = 1'b1;
    tk(); chk("R5 wait hold", {15'd0, s_rst}, 16'd0);
    in_wait = 1'b0;
    tk(); chk("R5 wait release", {15'd0, s_rst}, 16'd1);
    in_stop = 1'b1;
    tk(); chk("R5 stop ignored when bit clear", {15'd0, s_rst}, 16'd1);
    in_stop = 1'b0;
  endtask

  task automatic test_sw();
    wr(4'h0, 16'h0020);
    chk("R7 sw rst pulse", {15'd0, w_rst}, 16'd1);
    chk("R7 no wdo", {15'd0, w_wdo}, 16'd0);
    chk("R7 pulse one cycle", {15'd0, sys_rst_req}, 16'd0);
    rd(4'h4, rv); chk("R8 stat sw", rv, 16'h0001);
    wr(4'h0, 16'h0010);
    chk("R7 wdo pulse", {15'd0, w_wdo}, 16'd1);
    chk("R7 no rst", {15'd0, w_rst}, 16'd0);
    rd(4'h0, rv); chk("R7 bits read 1", rv, 16'h0030);
    wr(4'h4, 16'hFFFF);
    rd(4'h4, rv); chk("R8 stat write ignored", rv, 16'h0001);
  endtask

  task automatic test_long();
    int early;
    early = 0;
    wr(4'h0, 16'hFF34);
    for (int i = 0; i < 255; i++) begin tk(); if (s_rst) early++; end
    chk("R1 255 ticks no tout", 16'(early), 16'd0);
    tk(); chk("R1 256th tick tout", {15'd0, s_rst}, 16'd1);
    rd(4'h0, rv); chk("R1 ctrl readback", rv, 16'hFF34);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick_half_s = 1'b0; in_stop = 1'b0; in_debug = 1'b0; in_wait = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_disabled();
    test_timeout();
    test_service();
    test_badkey();
    test_irq();
    test_suspend();
    test_sw();
    test_long();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule